// File: doc/BRIEF.md
# Serial Step-Attenuator Programming Master

This block sits on the host side of a digital RF step attenuator and loads a 5-bit attenuation code into it over a three-wire serial link: a data line, a shift clock and a latch strobe. A client presents a code with a valid/ready handshake. The block then builds a 6-bit word made of a zero start bit followed by the code. It shifts the word out most significant bit first while the latch strobe stays low. After the last bit it raises the strobe for a short pulse so that the attenuator takes the new word.

Every interface time comes from the system clock. The block converts each minimum time, given in nanoseconds, into a cycle count and rounds that count up. These times are the shift-clock phase widths, the shift-clock rate ceiling, the data margin on either side of each clock edge, the strobe setup after the last falling edge, the strobe pulse width, and the minimum spacing of 40 µs between two latch events. The minimum spacing keeps the attenuator at or below its 25 kHz update ceiling. The client sees ready fall when a word is accepted. Ready stays low until that spacing has run out. A one-cycle done pulse marks the end of each latch pulse.

Top module: `atten_ser_master`

## Requirements
- R1: Each transfer carries exactly 6 bits, sampled by the attenuator on rising `ser_clk_o` edges. The first bit is a constant 0. It is followed by `code_i[4]` (8 dB weight), `code_i[3]`, `code_i[2]`, `code_i[1]`, and last `code_i[0]` (0.5 dB weight).
- R2: `ser_le_o` is low at every rising edge of `ser_clk_o`. The strobe never overlaps shifting.
- R3: Every high phase and every low phase of `ser_clk_o` lasts at least HALF cycles. HALF is the largest of: `SCLK_HALF_CYC`; the cycles in `MIN_PHASE_NS`; half the system clock over `MAX_SCLK_HZ`; and twice the data-margin cycles. All of these are rounded up.
- R4: `ser_data_o` changes only while `ser_clk_o` is low. Each change comes at least ceil(`DATA_MARGIN_NS`) cycles after the preceding falling edge and at least that many cycles before the next rising edge.
- R5: `ser_le_o` rises at least ceil(`LE_SETUP_NS`) cycles after the last falling edge of the word. It then stays high for at least ceil(`LE_PULSE_NS`) cycles.
- R6: Two rising edges of `ser_le_o` are at least ceil(`UPDATE_GAP_NS`) cycles apart. `ready_o` is low from acceptance until that many cycles have passed since the latest rising edge of `ser_le_o`. While `ready_o` is high, `ser_clk_o` and `ser_le_o` are low.
- R7: `done_o` is high for exactly one cycle. That cycle is the first one in which `ser_le_o` is low again after its pulse.
- R8: A code is taken only in a cycle where `valid_i` and `ready_o` are both high, and `ready_o` is low in the following cycle. While `ready_o` is low, `valid_i` and `code_i` are ignored: no word is sent for them afterwards.
- R9: While `rst_n` is low, and in the first cycle after it is released, `ready_o` is high and `ser_clk_o`, `ser_data_o`, `ser_le_o` and `done_o` are low. This holds even when reset arrives in the middle of a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_i | input | 5 | Attenuation code, LSB = 0.5 dB |
| valid_i | input | 1 | Code on `code_i` is offered |
| ready_o | output | 1 | Block can take a code this cycle |
| ser_clk_o | output | 1 | Serial shift clock to the attenuator |
| ser_data_o | output | 1 | Serial data to the attenuator |
| ser_le_o | output | 1 | Latch strobe to the attenuator |
| done_o | output | 1 | One-cycle pulse at the end of the latch pulse |

## Verification
The bench runs the block at 125 MHz. At that rate the 10 ns margins become 2 cycles, the 30 ns strobe pulse becomes 4 cycles, and the 40 µs spacing becomes 5000 cycles. The bench keeps the full update spacing, so the ready holdoff and the spacing between latch events are measured at their real length. It also asks for a shift-clock half period of only 2 cycles. That request sits below the floor, so the rate ceiling must raise it to 7 cycles, and the bench checks this clamp on every phase. Single-bit codes, all-ones, all-zeros and a mixed pattern show that each bit lands in its own position. A code offered while the block is busy, and a reset in the middle of a word, reach the ignore and recovery rules.

// File: rtl/atten_ser_pkg.sv
package atten_ser_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LE_WAIT,
        ST_LE_HIGH
    } xfer_state_e;

    // Nanoseconds to system cycles, rounded up, never below one.
    function automatic int ns_to_cyc(input longint ns, input longint hz);
        longint t;
        t = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (t < 1) ? 1 : int'(t);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/atten_frame_pack.sv
module atten_frame_pack #(
    parameter int   CODE_W    = 5,
    parameter logic START_BIT = 1'b0
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W:0]   frame_o
);
    // The start bit leads, then the code from its heaviest bit down.
    assign frame_o = {START_BIT, code_i};
endmodule

// File: rtl/atten_gap_timer.sv
module atten_gap_timer #(
    parameter int GAP_C = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);
    localparam int GAP_W = $clog2(GAP_C + 1);

    logic [GAP_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = GAP_W'(GAP_C);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - GAP_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/atten_ser_master.sv
module atten_ser_master
    import atten_ser_pkg::*;
#(
    parameter int CLK_HZ         = 125_000_000,
    parameter int SCLK_HALF_CYC  = 8,
    parameter int CODE_W         = 5,
    parameter int MAX_SCLK_HZ    = 10_000_000,
    parameter int MIN_PHASE_NS   = 30,
    parameter int DATA_MARGIN_NS = 10,
    parameter int LE_SETUP_NS    = 10,
    parameter int LE_PULSE_NS    = 30,
    parameter int UPDATE_GAP_NS  = 40_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              ser_clk_o,
    output logic              ser_data_o,
    output logic              ser_le_o,
    output logic              done_o
);
    localparam int FRAME_W   = CODE_W + 1;
    localparam int BIT_W     = $clog2(FRAME_W);
    localparam int MARGIN_C  = ns_to_cyc(DATA_MARGIN_NS, CLK_HZ);
    localparam int PH_MIN_C  = ns_to_cyc(MIN_PHASE_NS, CLK_HZ);
    localparam int PH_RATE_C = int'((longint'(CLK_HZ) + 2 * longint'(MAX_SCLK_HZ) - 1)
                                    / (2 * longint'(MAX_SCLK_HZ)));
    localparam int HALF_C    = imax(imax(SCLK_HALF_CYC, PH_MIN_C),
                                    imax(PH_RATE_C, 2 * MARGIN_C));
    localparam int MID_C     = HALF_C / 2;
    localparam int LE_SU_C   = ns_to_cyc(LE_SETUP_NS, CLK_HZ);
    localparam int LE_PW_C   = ns_to_cyc(LE_PULSE_NS, CLK_HZ);
    localparam int GAP_C     = ns_to_cyc(UPDATE_GAP_NS, CLK_HZ);
    localparam int CNT_W     = $clog2(imax(HALF_C, imax(LE_SU_C, LE_PW_C)) + 1);

    typedef struct packed {
        xfer_state_e        state;
        logic [CNT_W-1:0]   cnt;
        logic [BIT_W-1:0]   bits;
        logic [FRAME_W-1:0] shreg;
        logic               sclk;
        logic               sdata;
        logic               le;
        logic               done;
    } xfer_regs_t;

    xfer_regs_t         r_q, r_d;
    logic [FRAME_W-1:0] frame;
    logic               gap_load;
    logic               gap_busy;
    logic               take;

    atten_frame_pack #(
        .CODE_W    (CODE_W),
        .START_BIT (1'b0)
    ) u_pack (
        .code_i  (code_i),
        .frame_o (frame)
    );

    atten_gap_timer #(
        .GAP_C (GAP_C)
    ) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (gap_load),
        .busy_o (gap_busy)
    );

    assign ready_o = (r_q.state == ST_IDLE) && !gap_busy;
    assign take    = valid_i && ready_o;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        gap_load = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (take) begin
                    r_d.state = ST_LOW;
                    r_d.cnt   = '0;
                    r_d.bits  = BIT_W'(FRAME_W - 1);
                    r_d.shreg = frame;
                end
            end
            ST_LOW: begin
                // Data moves midway through the low phase: hold after the
                // previous fall and setup before the next rise both covered.
                if (r_q.cnt == CNT_W'(MID_C - 1)) begin
                    r_d.sdata = r_q.shreg[FRAME_W-1];
                    r_d.shreg = {r_q.shreg[FRAME_W-2:0], 1'b0};
                end
                if (r_q.cnt == CNT_W'(HALF_C - 1)) begin
                    r_d.sclk  = 1'b1;
                    r_d.state = ST_HIGH;
                    r_d.cnt   = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == CNT_W'(HALF_C - 1)) begin
                    r_d.sclk = 1'b0;
                    r_d.cnt  = '0;
                    if (r_q.bits == '0) begin
                        r_d.state = ST_LE_WAIT;
                    end else begin
                        r_d.state = ST_LOW;
                        r_d.bits  = r_q.bits - BIT_W'(1);
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_LE_WAIT: begin
                if (r_q.cnt == CNT_W'(LE_SU_C - 1)) begin
                    r_d.le    = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = ST_LE_HIGH;
                    gap_load  = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            ST_LE_HIGH: begin
                if (r_q.cnt == CNT_W'(LE_PW_C - 1)) begin
                    r_d.le    = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CNT_W'(1);
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, cnt: '0, bits: '0, shreg: '0,
                     sclk: 1'b0, sdata: 1'b0, le: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ser_clk_o  = r_q.sclk;
    assign ser_data_o = r_q.sdata;
    assign ser_le_o   = r_q.le;
    assign done_o     = r_q.done;

endmodule

// File: rtl/atten_ser_master_chk.sv
module atten_ser_master_chk #(
    parameter int HALF_C = 8
) (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic ready_o,
    input logic ser_clk_o,
    input logic ser_data_o,
    input logic ser_le_o,
    input logic done_o
);
    logic [15:0] ph_cnt;
    logic        ph_prev;

    // Width of each shift-clock phase, measured with a counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt  <= 16'hFFFF;
            ph_prev <= 1'b0;
        end else begin
            if (ser_clk_o != ph_prev) begin
                assert_phase_width_R3: assert (ph_cnt >= 16'(HALF_C))
                    else $error("shift clock phase of %0d cycles", ph_cnt);
                ph_cnt <= 16'd1;
            end else if (ph_cnt != 16'hFFFF) begin
                ph_cnt <= ph_cnt + 16'd1;
            end
            ph_prev <= ser_clk_o;
        end
    end

    assert_le_low_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_clk_o) |-> !ser_le_o);

    assert_data_quiet_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (!ser_clk_o && !ser_le_o));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_at_le_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!ser_le_o && $past(ser_le_o)));

    assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> !ready_o);

endmodule

bind atten_ser_master atten_ser_master_chk #(
    .HALF_C (HALF_C)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid_i    (valid_i),
    .ready_o    (ready_o),
    .ser_clk_o  (ser_clk_o),
    .ser_data_o (ser_data_o),
    .ser_le_o   (ser_le_o),
    .done_o     (done_o)
);

// File: tb/atten_ser_master_test.sv
`timescale 1ns/1ps
module atten_ser_master_test;

    // Expected cycle counts at 125 MHz (8 ns), worked out from the requirements.
    localparam int HALF_EXP = 7;     // 10 MHz ceiling: 50 ns / 8 ns -> 7
    localparam int SU_EXP   = 2;     // 10 ns -> 2
    localparam int LEPW_EXP = 4;     // 30 ns -> 4
    localparam int GAP_EXP  = 5000;  // 40 us -> 5000
    localparam int NVEC     = 8;

    localparam logic [4:0] VEC_CODE  [NVEC] = '{5'd0, 5'd1, 5'd2, 5'd4,
                                                5'd8, 5'd16, 5'd31, 5'd21};
    localparam logic [5:0] VEC_FRAME [NVEC] = '{6'h00, 6'h01, 6'h02, 6'h04,
                                                6'h08, 6'h10, 6'h1F, 6'h15};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] code_i = '0;
    logic       valid_i = 1'b0;
    logic       ready_o, ser_clk_o, ser_data_o, ser_le_o, done_o;

    logic [5:0] exp_frame = '0;
    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;

    always #4 clk = ~clk;

    atten_ser_master #(
        .SCLK_HALF_CYC (2)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .code_i     (code_i),
        .valid_i    (valid_i),
        .ready_o    (ready_o),
        .ser_clk_o  (ser_clk_o),
        .ser_data_o (ser_data_o),
        .ser_le_o   (ser_le_o),
        .done_o     (done_o)
    );

    // ---------------- port monitor ----------------
    int         cyc = 0, phase_start = 0, last_fall = -1000, last_dchg = -1000;
    int         le_rise = 0, nbits = 0;
    bit         have_rise = 1'b0;
    logic       pclk = 1'b0, pdata = 1'b0, ple = 1'b0;
    logic [5:0] cap = '0;

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        m_chk++;
        if (!ok) begin
            m_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            pclk = 1'b0; pdata = 1'b0; ple = 1'b0; nbits = 0; cap = '0;
            last_fall = -1000; last_dchg = -1000; have_rise = 1'b0;
            phase_start = cyc;
        end else begin
            cyc++;
            if (ser_clk_o !== pclk) begin
                mchk(cyc - phase_start >= HALF_EXP, "R3 phase width", cyc - phase_start, HALF_EXP);
                if (ser_clk_o) begin
                    mchk(!ser_le_o && !ple, "R2 strobe low at rising clock", int'(ser_le_o), 0);
                    mchk(cyc - last_dchg >= SU_EXP, "R4 setup before rise", cyc - last_dchg, SU_EXP);
                    cap = {cap[4:0], ser_data_o};
                    nbits++;
                end else begin
                    last_fall = cyc;
                end
                phase_start = cyc;
            end
            if (ser_data_o !== pdata) begin
                mchk(!ser_clk_o && !pclk, "R4 data moves with clock low", int'(ser_clk_o), 0);
                mchk(cyc - last_fall >= SU_EXP, "R4 hold after fall", cyc - last_fall, SU_EXP);
                last_dchg = cyc;
            end
            if (ser_le_o && !ple) begin
                mchk(nbits == 6, "R1 bit count", nbits, 6);
                mchk(cap == exp_frame, "R1 frame content", int'(cap), int'(exp_frame));
                mchk(cyc - last_fall >= SU_EXP, "R5 strobe setup", cyc - last_fall, SU_EXP);
                if (have_rise)
                    mchk(cyc - le_rise >= GAP_EXP, "R6 latch spacing", cyc - le_rise, GAP_EXP);
                le_rise = cyc;
                have_rise = 1'b1;
                nbits = 0;
            end
            if (!ser_le_o && ple) begin
                mchk(cyc - le_rise >= LEPW_EXP, "R5 strobe width", cyc - le_rise, LEPW_EXP);
                mchk(done_o, "R7 done at strobe fall", int'(done_o), 1);
            end
            if (done_o)
                mchk(ple && !ser_le_o, "R7 done placement", int'(ser_le_o), 0);
            pclk = ser_clk_o; pdata = ser_data_o; ple = ser_le_o;
        end
    end

    // ---------------- stimulus ----------------
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic [4:0] c, input logic [5:0] f);
        while (!ready_o) @(negedge clk);
        code_i    = c;
        valid_i   = 1'b1;
        exp_frame = f;
        @(negedge clk);
        valid_i = 1'b0;
        chk(!ready_o, "R8 ready low after accept", int'(ready_o), 0);
    endtask

    task automatic wait_done_and_gap();
        int w;
        while (!done_o) @(negedge clk);
        @(negedge clk);
        chk(!done_o, "R7 done lasts one cycle", int'(done_o), 0);
        chk(!ready_o, "R6 ready low after latch", int'(ready_o), 0);
        w = 1;
        while (!ready_o) begin
            @(negedge clk);
            w++;
        end
        // done comes LEPW_EXP cycles after the strobe rise
        chk(w + LEPW_EXP >= GAP_EXP, "R6 ready holdoff", w + LEPW_EXP, GAP_EXP);
    endtask

    task automatic chk_reset_state(input string tag);
        chk(ready_o && !ser_clk_o && !ser_data_o && !ser_le_o && !done_o, tag,
            {27'd0, ready_o, ser_clk_o, ser_data_o, ser_le_o, done_o}, 16);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        chk_reset_state("R9 outputs in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("R9 outputs after release");

        // Table walk: R1 bit placement for each code
        for (int i = 0; i < NVEC; i++) begin
            send(VEC_CODE[i], VEC_FRAME[i]);
            wait_done_and_gap();
        end

        // R8: code offered while busy is ignored
        send(5'd3, 6'h03);
        repeat (2) @(negedge clk);
        code_i  = 5'd28;
        valid_i = 1'b1;
        repeat (60) @(negedge clk);
        valid_i = 1'b0;
        wait_done_and_gap();
        repeat (20) @(negedge clk);
        chk(ready_o && !ser_clk_o && !ser_le_o, "R8 busy offer ignored",
            int'(ser_clk_o), 0);
        send(5'd9, 6'h09);
        wait_done_and_gap();

        // R9: reset in the middle of a word
        send(5'd27, 6'h1B);
        repeat (40) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk_reset_state("R9 mid-word reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_reset_state("R9 after mid-word reset");
        send(5'd18, 6'h12);
        wait_done_and_gap();

        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk, n_fail + m_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures",
                 n_chk + m_chk + 1, n_fail + m_fail + 1);
        $finish;
    end

endmodule